// File: doc/BRIEF.md
# Paced Energy Pulse Generator

This block sits between a metering engine and two output pins. The engine emits single-cycle request strobes, one stream for real energy and one for reactive energy. Each channel counts its outstanding requests and releases them as pulses on its pin. Releases are spaced by a programmed period, so a burst of requests leaves the pin as an evenly paced train rather than a clump.

The period is four times an 8-bit spacing value, counted in sample-clock cycles. The active part of each pulse is capped at a programmed width ceiling and never exceeds half the period. When the spacing value is zero, pacing is skipped: each request starts a pulse at once. Such a pulse has equal active and idle halves whose length is a build parameter, and requests that arrive meanwhile wait their turn. A single polarity bit selects whether both pins idle high and pulse low, or the reverse. The two channels share only the clock and the configuration inputs.

Top module: `epg_pulse_gen`

## Requirements
- R1: With spacing value S > 0 and requests outstanding, consecutive pulse starts on a channel are exactly 4·S cycles apart.
- R2: With S = 0, a request reaching an idle channel makes its pin active in the very next cycle. The pin stays active for BYP_HALF cycles (default 4) and then idles for BYP_HALF cycles.
- R3: Each channel's pending count saturates at 2^CNT_W − 1 (15 by default). Requests beyond that are dropped: 20 back-to-back requests with S = 8 yield exactly 16 pulses.
- R4: A request in the same cycle as a release leaves the pending count unchanged and loses no request: 20 back-to-back requests with S = 4 yield exactly 17 pulses.
- R5: With S > 0, the active width is min((2·W + 1)·S, 2·S) cycles, where W is the width ceiling value. For W = 255 the width is 2·S, which is 50% duty.
- R6: With S = 0, a request arriving during a pulse is queued, and its pulse starts in the cycle right after the earlier pulse's period ends. Several queued requests therefore give pulse starts 2·BYP_HALF cycles apart.
- R7: When the polarity bit is 0, an idle pin is 1 and an active pin is 0. When the bit is 1, both levels are inverted, on both pins.
- R8: A change of S while pulses are pending leaves the current period as it is. The new period and width apply from the next release on.
- R9: Requests on one channel never cause pulses on the other.
- R10: After reset, no pulse is in progress, nothing is pending, and both pins sit at the inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; all timing is counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_real | input | 1 | One-cycle request strobe for the real-energy channel |
| req_reac | input | 1 | One-cycle request strobe for the reactive-energy channel |
| spacing | input | 8 | Spacing value S; the period is 4·S cycles, and 0 selects immediate mode |
| width_cap | input | 8 | Width ceiling value W; 255 disables the ceiling |
| invert | input | 1 | Polarity select: 0 for active-low pins, 1 for active-high pins |
| pin_real | output | 1 | Real-energy pulse pin |
| pin_reac | output | 1 | Reactive-energy pulse pin |

## Verification
On every cycle, the in-line assertions check the following:
- the pending count cannot wrap past its ceiling;
- a same-cycle request and release leave the count where it was;
- every release is backed by a request or a pending entry;
- each release starts an active phase on the next cycle;
- a finished period returns the channel to idle unless another release follows.

Some behaviour shows only in the bench's sweeps over spacing and width values, where it measures timing at the pins:
- the exact pulse spacing and width;
- immediate-mode latency and queuing;
- the point at which a spacing change takes effect;
- the lost-request counts;
- channel isolation.

// File: rtl/epg_pkg.sv
package epg_pkg;
  parameter int unsigned REG_W = 8;
  localparam int unsigned TIM_W = REG_W + 2;
  localparam int unsigned PRD_W = 2 * REG_W + 2;

  typedef logic [REG_W-1:0] cfg_t;
  typedef logic [TIM_W-1:0] tim_t;

  // Full period of one released pulse, in clock cycles.
  function automatic tim_t period_len(cfg_t sp, tim_t half);
    if (sp == '0) return tim_t'(half << 1);
    return {sp, 2'b00};
  endfunction

  // Active-phase length: the width ceiling or half the period, whichever is shorter.
  function automatic tim_t active_len(cfg_t sp, cfg_t wc, tim_t half);
    logic [PRD_W-1:0] lim;
    tim_t             halfp;
    if (sp == '0) return half;
    halfp = {1'b0, sp, 1'b0};
    if (wc == '1) return halfp;
    lim = {{REG_W{1'b0}}, 1'b0, wc, 1'b1} * {{(REG_W+2){1'b0}}, sp};
    if (lim < {{REG_W{1'b0}}, halfp}) return tim_t'(lim);
    return halfp;
  endfunction
endpackage

// File: rtl/epg_pend.sv
module epg_pend #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             rel_i,
  output logic             nz_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      case ({req_i, rel_i})
        2'b10:   if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        2'b01:   if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign nz_o  = (cnt_q != '0);
  assign cnt_o = cnt_q;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && req_i && !rel_i) |=> (cnt_q == CNT_MAX));

  assert_hold_on_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && rel_i) |=> $stable(cnt_q));
endmodule

// File: rtl/epg_shaper.sv
module epg_shaper
  import epg_pkg::*;
#(
  parameter int unsigned BYP_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_i,
  input  cfg_t sp_i,
  input  cfg_t wc_i,
  output logic rel_o,
  output logic active_o
);
  localparam tim_t HALF = tim_t'(BYP_HALF);

  logic busy_q;
  tim_t el_q;
  tim_t per_q;
  tim_t act_q;
  logic period_end;

  assign period_end = busy_q && (el_q == per_q - 1'b1);
  assign rel_o      = want_i && (!busy_q || period_end);
  assign active_o   = busy_q && (el_q < act_q);

  // Period and width are latched at release, so a spacing change only affects later pulses.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      el_q   <= '0;
      per_q  <= '0;
      act_q  <= '0;
    end else if (rel_o) begin
      busy_q <= 1'b1;
      el_q   <= '0;
      per_q  <= period_len(sp_i, HALF);
      act_q  <= active_len(sp_i, wc_i, HALF);
    end else if (period_end) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      el_q <= el_q + 1'b1;
    end
  end

  assert_release_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rel_o |=> (active_o && el_q == '0));

  assert_period_closes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && !want_i) |=> !busy_q);
endmodule

// File: rtl/epg_pulse_gen.sv
module epg_pulse_gen
  import epg_pkg::*;
#(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned BYP_HALF = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_real,
  input  logic             req_reac,
  input  logic [REG_W-1:0] spacing,
  input  logic [REG_W-1:0] width_cap,
  input  logic             invert,
  output logic             pin_real,
  output logic             pin_reac
);
  localparam int unsigned N_CH = 2;

  logic [N_CH-1:0] req_v;
  logic [N_CH-1:0] rel_v;
  logic [N_CH-1:0] nz_v;
  logic [N_CH-1:0] act_v;

  assign req_v = {req_reac, req_real};

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic [CNT_W-1:0] cnt;

    epg_pend #(.CNT_W(CNT_W)) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (req_v[ch]),
      .rel_i (rel_v[ch]),
      .nz_o  (nz_v[ch]),
      .cnt_o (cnt)
    );

    epg_shaper #(.BYP_HALF(BYP_HALF)) u_shaper (
      .clk      (clk),
      .rst_n    (rst_n),
      .want_i   (nz_v[ch] | req_v[ch]),
      .sp_i     (spacing),
      .wc_i     (width_cap),
      .rel_o    (rel_v[ch]),
      .active_o (act_v[ch])
    );

    assert_release_backed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rel_v[ch] |-> (cnt != '0 || req_v[ch]));
  end

  assign pin_real = act_v[0] ^ ~invert;
  assign pin_reac = act_v[1] ^ ~invert;
endmodule

// File: tb/epg_pulse_gen_bench.sv
module epg_pulse_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_real = 1'b0, req_reac = 1'b0;
  logic [7:0] spacing = 8'd0, width_cap = 8'hFF;
  logic       invert = 1'b0;
  logic       pin_real, pin_reac;

  int cyc = 0, vecs = 0, fails = 0;
  logic mon_clr = 1'b1;
  int st[2][64];
  int wd[2][64];
  int np[2];
  int ns[2];
  bit prev[2];

  epg_pulse_gen u_epg_pulse_gen (
    .clk(clk), .rst_n(rst_n), .req_real(req_real), .req_reac(req_reac),
    .spacing(spacing), .width_cap(width_cap), .invert(invert),
    .pin_real(pin_real), .pin_reac(pin_reac));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Pin monitor: records the rise cycle and width of each pulse.
  always @(negedge clk) begin
    bit a[2];
    a[0] = invert ? pin_real : ~pin_real;
    a[1] = invert ? pin_reac : ~pin_reac;
    for (int c = 0; c < 2; c++) begin
      if (mon_clr) begin
        np[c] = 0; ns[c] = 0; prev[c] = a[c];
      end else begin
        if (a[c] && !prev[c] && ns[c] < 64) begin st[c][ns[c]] = cyc; ns[c]++; end
        if (!a[c] && prev[c] && np[c] < 64) begin wd[c][np[c]] = cyc - st[c][np[c]]; np[c]++; end
        prev[c] = a[c];
      end
    end
  end

  task automatic check(bit ok, string rq, int act, int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic verify(int c, int n, int aw, int per, string rq);
    int bad_w = 0, bad_s = 0;
    check(np[c] == n, rq, np[c], n);
    for (int i = 0; i < np[c]; i++) if (wd[c][i] != aw) bad_w++;
    check(bad_w == 0, rq, bad_w, 0);
    for (int i = 1; i < ns[c]; i++) if (st[c][i] - st[c][i-1] != per) bad_s++;
    check(bad_s == 0, rq, bad_s, 0);
  endtask

  function automatic int exp_w(int s, int w);
    int lim;
    if (w == 255) return 2 * s;
    lim = (2 * w + 1) * s;
    return (lim < 2 * s) ? lim : 2 * s;
  endfunction

  task automatic burst(int s, int w, int n0, int n1, int wait_cyc);
    int m;
    @(negedge clk);
    spacing = 8'(s); width_cap = 8'(w); mon_clr = 1'b1;
    @(negedge clk);
    mon_clr = 1'b0;
    m = (n0 > n1) ? n0 : n1;
    for (int k = 0; k < m; k++) begin
      req_real = (k < n0); req_reac = (k < n1);
      @(negedge clk);
    end
    req_real = 1'b0; req_reac = 1'b0;
    repeat (wait_cyc) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    int s_list[4] = '{1, 2, 3, 5};
    int w_list[4] = '{0, 1, 2, 255};
    repeat (3) @(negedge clk);
    // R10: reset state, pins idle high under active-low polarity
    check(pin_real == 1'b1 && pin_reac == 1'b1, "R10", {pin_real, pin_reac}, 3);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(pin_real == 1'b1 && pin_reac == 1'b1, "R10", {pin_real, pin_reac}, 3);

    // R7: inverted polarity idles low, then pulses high
    invert = 1'b1;
    @(negedge clk);
    check(pin_real == 1'b0 && pin_reac == 1'b0, "R7", {pin_real, pin_reac}, 0);
    req_real = 1'b1;
    @(negedge clk);
    req_real = 1'b0;
    check(pin_real == 1'b1 && pin_reac == 1'b0, "R7", {pin_real, pin_reac}, 2);
    repeat (12) @(negedge clk);
    invert = 1'b0;

    // R2: immediate mode latency of one cycle
    @(negedge clk);
    req_reac = 1'b1;
    @(negedge clk);
    req_reac = 1'b0;
    check(pin_reac == 1'b0, "R2", pin_reac, 0);
    repeat (12) @(negedge clk);

    // R1, R5, R9: sweep over spacing and width ceiling, both channels at once
    foreach (s_list[i]) foreach (w_list[j]) begin
      burst(s_list[i], w_list[j], 3, 2, 5 * 4 * s_list[i] + 10);
      verify(0, 3, exp_w(s_list[i], w_list[j]), 4 * s_list[i], "R1_R5");
      verify(1, 2, exp_w(s_list[i], w_list[j]), 4 * s_list[i], "R9_R5");
    end

    // R2, R6: immediate mode with queued requests; the ceiling is ignored
    burst(0, 7, 3, 0, 40);
    verify(0, 3, 4, 8, "R6");
    check(np[1] == 0, "R9", np[1], 0);

    // R3: saturation loses the excess requests
    burst(8, 255, 20, 0, 17 * 32 + 10);
    check(np[0] == 16, "R3", np[0], 16);

    // R4: a release in the same cycle as a request keeps that request
    burst(4, 255, 20, 0, 18 * 16 + 10);
    check(np[0] == 17, "R4", np[0], 17);

    // R8: a spacing change takes effect at the next release
    burst(2, 255, 3, 0, 0);
    spacing = 8'd5;
    repeat (80) @(negedge clk);
    check(np[0] == 3, "R8", np[0], 3);
    check(wd[0][0] == 4, "R8", wd[0][0], 4);
    check(wd[0][1] == 10 && wd[0][2] == 10, "R8", wd[0][1], 10);
    check(st[0][1] - st[0][0] == 8, "R8", st[0][1] - st[0][0], 8);
    check(st[0][2] - st[0][1] == 20, "R8", st[0][2] - st[0][1], 20);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule